// File: doc/BRIEF.md
# Four-Channel Ready and Interrupt Aggregator

This block sits beside four UART channels and turns their FIFO fill state and interrupt conditions into shared flow signals for a DMA controller and per-channel interrupt pins. For every channel it keeps one receive-ready flag and one transmit-ready flag. Each flag has set and clear conditions with a hold band between them, so a FIFO level that wanders between the thresholds does not toggle the strobes. The flags of all channels are merged into two active-low ready outputs, and the same flags are exposed together in one status byte that software can read in a single access.

Each channel's interrupt request is the OR of its four condition inputs, each masked by its own enable bit. The request drives an active-high interrupt pin. The pin's output enable comes either from the channel's modem-control enable bit or, when the shared select input is high, is forced on for every channel. FIFOs, serial engines and register decoding live outside the block.

Top module: `chan_ready_irq_agg`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `statusByte` is 0, `rxRdyN` and `txRdyN` are 1, and `irqOe` and `irqOut` are all 0.
- R2: A channel's RX-ready flag is set one clock after its RX level is nonzero, its error input is low, and either the level is at least the channel's RX trigger or the timeout input is high.
- R3: A channel's RX-ready flag is cleared one clock after its RX level is 0 or its error input is high. Clearing takes priority over setting.
- R4: When neither the set nor the clear condition of R2/R3 holds, for example a nonzero level below the trigger with timeout low, the RX-ready flag keeps its value.
- R5: `rxRdyN` is low exactly when at least one channel's RX-ready flag is set.
- R6: A channel's TX-ready flag is set one clock after its TX free count is nonzero and at least its TX trigger. It is cleared one clock after the free count is 0. Otherwise it holds.
- R7: `txRdyN` is low while any channel's TX-ready flag is set. It goes high only when every channel's flag is clear.
- R8: `statusByte` bit n (n = 0..3) is channel n's TX-ready flag, and bit 4+n is channel n's RX-ready flag, all active high.
- R9: A channel's interrupt request is the OR over its four condition bits ANDed with the matching enable bits (bit k of the channel's 4-bit field pairs with bit k). It appears on `irqOut` one clock later if that channel's output enable is on.
- R10: `irqOe[n]` equals `mcrIntEn[n]` of the previous clock when `intSel` was low. `irqOut[n]` is 0 whenever `irqOe[n]` is 0.
- R11: With `intSel` high, every `irqOe` bit is 1 one clock later, regardless of `mcrIntEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxLevel | input | 28 | Per-channel RX FIFO occupancy, 7 bits each, channel n at [7n+6:7n] |
| rxTrig | input | 28 | Per-channel RX trigger level |
| rxTimeout | input | 4 | Per-channel receive timeout pending |
| rxErr | input | 4 | Per-channel error held in RX FIFO |
| txFree | input | 28 | Per-channel TX FIFO free slots |
| txTrig | input | 28 | Per-channel TX trigger level |
| ierBits | input | 16 | Per-channel interrupt enables, 4 bits each |
| irqCond | input | 16 | Per-channel pending interrupt conditions, 4 bits each |
| mcrIntEn | input | 4 | Per-channel modem-control output-enable bit |
| intSel | input | 1 | Forces all interrupt output enables on |
| rxRdyN | output | 1 | Active-low merged receive ready |
| txRdyN | output | 1 | Active-low merged transmit ready |
| irqOut | output | 4 | Active-high per-channel interrupt pins |
| irqOe | output | 4 | Per-channel interrupt output enable |
| statusByte | output | 8 | All channels' ready flags, TX in 3:0, RX in 7:4 |

## Verification
The flags are the only state besides the interrupt registers. A wrong flag therefore shows up on `statusByte` and on the merged strobe on the first clock after the stimulus. The bench covers the hold band, where the inputs alone do not decide the output: it moves a level into the band from both sides and checks that the flag reflects history. Priority of error over timeout, a multi-channel merge in which one channel drops while another stays ready, and the select override of the enable bit each produce a distinct single-cycle result at the ports.

// File: rtl/chan_ready_pkg.sv
package chan_ready_pkg;

  // Per-channel strobes from the decision logic to the state holder.
  typedef struct packed {
    logic rxSet;
    logic rxClr;
    logic txSet;
    logic txClr;
    logic irqReq;
    logic oeReq;
  } chanStrobe_t;

endpackage

// File: rtl/chan_ready_ctrl.sv
module chan_ready_ctrl
  import chan_ready_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_SRC    = 4,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [NUM_CH*LW-1:0]      rxLevel,
  input  logic [NUM_CH*LW-1:0]      rxTrig,
  input  logic [NUM_CH-1:0]         rxTimeout,
  input  logic [NUM_CH-1:0]         rxErr,
  input  logic [NUM_CH*LW-1:0]      txFree,
  input  logic [NUM_CH*LW-1:0]      txTrig,
  input  logic [NUM_CH*NUM_SRC-1:0] ierBits,
  input  logic [NUM_CH*NUM_SRC-1:0] irqCond,
  input  logic [NUM_CH-1:0]         mcrIntEn,
  input  logic                      intSel,
  output chanStrobe_t [NUM_CH-1:0]  strobes
);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [LW-1:0]      lvl;
    logic [LW-1:0]      rTrig;
    logic [LW-1:0]      free;
    logic [LW-1:0]      tTrig;
    logic [NUM_SRC-1:0] masked;
    logic               rxEmpty;
    logic               txFull;

    assign lvl     = rxLevel[g*LW +: LW];
    assign rTrig   = rxTrig[g*LW +: LW];
    assign free    = txFree[g*LW +: LW];
    assign tTrig   = txTrig[g*LW +: LW];
    assign rxEmpty = (lvl == '0);
    assign txFull  = (free == '0);
    assign masked  = ierBits[g*NUM_SRC +: NUM_SRC] & irqCond[g*NUM_SRC +: NUM_SRC];

    // Receive side: threshold or timeout arms, empty or error disarms.
    assign strobes[g].rxClr  = rxErr[g] | rxEmpty;
    assign strobes[g].rxSet  = !rxEmpty && ((lvl >= rTrig) || rxTimeout[g]);

    // Transmit side: enough room arms, no room disarms.
    assign strobes[g].txClr  = txFull;
    assign strobes[g].txSet  = !txFull && (free >= tTrig);

    // Interrupt request and its pin enable.
    assign strobes[g].irqReq = |masked;
    assign strobes[g].oeReq  = intSel | mcrIntEn[g];
  end

endmodule

// File: rtl/chan_ready_dpath.sv
module chan_ready_dpath
  import chan_ready_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  chanStrobe_t [NUM_CH-1:0] strobes,
  output logic                     rxRdyN,
  output logic                     txRdyN,
  output logic [NUM_CH-1:0]        irqOut,
  output logic [NUM_CH-1:0]        irqOe,
  output logic [2*NUM_CH-1:0]      statusByte
);

  logic [NUM_CH-1:0] rxReadyQ;
  logic [NUM_CH-1:0] txReadyQ;
  logic [NUM_CH-1:0] irqQ;
  logic [NUM_CH-1:0] oeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxReadyQ <= '0;
      txReadyQ <= '0;
      irqQ     <= '0;
      oeQ      <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (strobes[i].rxClr)      rxReadyQ[i] <= 1'b0;
        else if (strobes[i].rxSet) rxReadyQ[i] <= 1'b1;
        if (strobes[i].txClr)      txReadyQ[i] <= 1'b0;
        else if (strobes[i].txSet) txReadyQ[i] <= 1'b1;
        irqQ[i] <= strobes[i].irqReq;
        oeQ[i]  <= strobes[i].oeReq;
      end
    end
  end

  assign rxRdyN     = ~|rxReadyQ;
  assign txRdyN     = ~|txReadyQ;
  assign irqOut     = irqQ & oeQ;
  assign irqOe      = oeQ;
  assign statusByte = {rxReadyQ, txReadyQ};

  for (genvar a = 0; a < NUM_CH; a++) begin : gChk
    AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
      (strobes[a].rxSet && !strobes[a].rxClr) |=> statusByte[NUM_CH+a]); // R2
    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
      strobes[a].rxClr |=> !statusByte[NUM_CH+a]); // R3
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!strobes[a].rxSet && !strobes[a].rxClr) |=> $stable(rxReadyQ[a])); // R4
    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (rst)
      strobes[a].txClr |=> !statusByte[a]); // R6
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!strobes[a].txSet && !strobes[a].txClr) |=> $stable(txReadyQ[a])); // R6
    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (strobes[a].irqReq && strobes[a].oeReq) |=> irqOut[a]); // R9
  end

endmodule

// File: rtl/chan_ready_irq_agg.sv
module chan_ready_irq_agg
  import chan_ready_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_SRC    = 4,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH*LW-1:0]      rxLevel,
  input  logic [NUM_CH*LW-1:0]      rxTrig,
  input  logic [NUM_CH-1:0]         rxTimeout,
  input  logic [NUM_CH-1:0]         rxErr,
  input  logic [NUM_CH*LW-1:0]      txFree,
  input  logic [NUM_CH*LW-1:0]      txTrig,
  input  logic [NUM_CH*NUM_SRC-1:0] ierBits,
  input  logic [NUM_CH*NUM_SRC-1:0] irqCond,
  input  logic [NUM_CH-1:0]         mcrIntEn,
  input  logic                      intSel,
  output logic                      rxRdyN,
  output logic                      txRdyN,
  output logic [NUM_CH-1:0]         irqOut,
  output logic [NUM_CH-1:0]         irqOe,
  output logic [2*NUM_CH-1:0]       statusByte
);

  chanStrobe_t [NUM_CH-1:0] strobes;

  chan_ready_ctrl #(
    .NUM_CH    (NUM_CH),
    .FIFO_DEPTH(FIFO_DEPTH),
    .NUM_SRC   (NUM_SRC)
  ) i_ctrl (
    .rxLevel  (rxLevel),
    .rxTrig   (rxTrig),
    .rxTimeout(rxTimeout),
    .rxErr    (rxErr),
    .txFree   (txFree),
    .txTrig   (txTrig),
    .ierBits  (ierBits),
    .irqCond  (irqCond),
    .mcrIntEn (mcrIntEn),
    .intSel   (intSel),
    .strobes  (strobes)
  );

  chan_ready_dpath #(
    .NUM_CH(NUM_CH)
  ) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .rxRdyN    (rxRdyN),
    .txRdyN    (txRdyN),
    .irqOut    (irqOut),
    .irqOe     (irqOe),
    .statusByte(statusByte)
  );

  AST_INTSEL_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    intSel |=> (irqOe == '1)); // R11

  for (genvar p = 0; p < NUM_CH; p++) begin : gPin
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
      !irqOe[p] |-> !irqOut[p]); // R10
    AST_OE_FROM_MCR: assert property (@(posedge clk) disable iff (rst)
      !intSel |=> (irqOe[p] == $past(mcrIntEn[p]))); // R10
  end

endmodule

// File: tb/test_chan_ready_irq_agg.sv
module test_chan_ready_irq_agg;

  localparam int NCH = 4;
  localparam int LW  = 7;
  localparam int NS  = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH*LW-1:0] rxLevel = '0, rxTrig = '0, txFree = '0, txTrig = '0;
  logic [NCH-1:0]    rxTimeout = '0, rxErr = '0, mcrIntEn = '0;
  logic [NCH*NS-1:0] ierBits = '0, irqCond = '0;
  logic              intSel = 1'b0;
  logic              rxRdyN, txRdyN;
  logic [NCH-1:0]    irqOut, irqOe;
  logic [2*NCH-1:0]  statusByte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  chan_ready_irq_agg i_chan_ready_irq_agg (
    .clk(clk), .rst(rst),
    .rxLevel(rxLevel), .rxTrig(rxTrig), .rxTimeout(rxTimeout), .rxErr(rxErr),
    .txFree(txFree), .txTrig(txTrig), .ierBits(ierBits), .irqCond(irqCond),
    .mcrIntEn(mcrIntEn), .intSel(intSel),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN), .irqOut(irqOut), .irqOe(irqOe),
    .statusByte(statusByte)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // Inputs change right after a falling edge; one rising edge later the
  // registered result is sampled at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setRx(input int ch, input int lvl, input int trig);
    rxLevel[ch*LW +: LW] = LW'(lvl);
    rxTrig[ch*LW +: LW]  = LW'(trig);
  endtask

  task automatic setTx(input int ch, input int free, input int trig);
    txFree[ch*LW +: LW] = LW'(free);
    txTrig[ch*LW +: LW] = LW'(trig);
  endtask

  task automatic t_reset();
    check({31'd0, rxRdyN}, 1, "R1 rxRdyN during reset");
    rst = 1'b0;
    check(statusByte, 0, "R1 statusByte after reset");
    check({31'd0, rxRdyN}, 1, "R1 rxRdyN after reset");
    check({31'd0, txRdyN}, 1, "R1 txRdyN after reset");
    check(irqOe, 0, "R1 irqOe after reset");
    check(irqOut, 0, "R1 irqOut after reset");
  endtask

  task automatic t_rx_trigger();
    setRx(1, 5, 8); tick();
    check(statusByte, 8'h00, "R2 below trigger does not set");
    setRx(2, 8, 8); tick();
    check(statusByte, 8'h40, "R2/R8 channel 2 at trigger");
    check({31'd0, rxRdyN}, 0, "R5 rxRdyN low with one ready");
    setRx(2, 3, 8); tick();
    check(statusByte, 8'h40, "R4 hold below trigger");
    setRx(2, 0, 8); tick();
    check(statusByte, 8'h00, "R3 clear on empty");
    check({31'd0, rxRdyN}, 1, "R5 rxRdyN high when none ready");
    setRx(1, 0, 0);
  endtask

  task automatic t_rx_timeout();
    setRx(0, 2, 16); rxTimeout[0] = 1'b1; tick();
    check(statusByte, 8'h10, "R2 timeout sets channel 0");
    rxTimeout[0] = 1'b0; tick();
    check(statusByte, 8'h10, "R4 hold after timeout drops");
    rxErr[0] = 1'b1; rxTimeout[0] = 1'b1; tick();
    check(statusByte, 8'h00, "R3 error beats timeout");
    rxErr[0] = 1'b0; rxTimeout[0] = 1'b0; tick();
    check(statusByte, 8'h00, "R4 hold clear below trigger");
    setRx(3, 20, 16); tick();
    check(statusByte, 8'h80, "R8 channel 3 RX in bit 7");
    setRx(0, 0, 0); setRx(3, 0, 0); tick();
    check(statusByte, 8'h00, "R3 both cleared on empty");
  endtask

  task automatic t_tx();
    setTx(3, 4, 8); tick();
    check(statusByte, 8'h00, "R6 free below trigger");
    check({31'd0, txRdyN}, 1, "R7 txRdyN high none ready");
    setTx(3, 8, 8); tick();
    check(statusByte, 8'h08, "R6/R8 channel 3 TX in bit 3");
    check({31'd0, txRdyN}, 0, "R7 txRdyN low");
    setTx(3, 2, 8); tick();
    check(statusByte, 8'h08, "R6 hold with little room");
    setTx(0, 1, 1); tick();
    check(statusByte, 8'h09, "R6 channel 0 ready");
    setTx(3, 0, 8); tick();
    check(statusByte, 8'h01, "R6 clear on full");
    check({31'd0, txRdyN}, 0, "R7 one channel still ready");
    setTx(0, 0, 1); tick();
    check({31'd0, txRdyN}, 1, "R7 all full releases strobe");
  endtask

  task automatic t_irq();
    ierBits[1*NS +: NS] = 4'b0010;
    irqCond[1*NS +: NS] = 4'b0001; tick();
    check(irqOe, 4'h0, "R10 enable off without mcr");
    check(irqOut, 4'h0, "R10 pin quiet");
    mcrIntEn[1] = 1'b1; tick();
    check(irqOe, 4'h2, "R10 mcr enables channel 1");
    check(irqOut, 4'h0, "R9 masked condition gives no request");
    irqCond[1*NS +: NS] = 4'b0011; tick();
    check(irqOut, 4'h2, "R9 enabled condition raises pin");
    ierBits[1*NS +: NS] = 4'b1111;
    irqCond[1*NS +: NS] = 4'b1000; tick();
    check(irqOut, 4'h2, "R9 OR over sources");
    mcrIntEn[1] = 1'b0; tick();
    check(irqOe, 4'h0, "R10 mcr off disables");
    check(irqOut, 4'h0, "R10 pin quiet when disabled");
  endtask

  task automatic t_intsel();
    intSel = 1'b1; tick();
    check(irqOe, 4'hF, "R11 select forces all enables");
    check(irqOut, 4'h2, "R11 request reaches pin");
    intSel = 1'b0; mcrIntEn = 4'b0100; tick();
    check(irqOe, 4'h4, "R10 enables follow mcr again");
    check(irqOut, 4'h0, "R10 channel 1 quiet again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rx_trigger();
    t_rx_timeout();
    t_tx();
    t_irq();
    t_intsel();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule